// File: doc/BRIEF.md
# Flash Multi-Word Program Command Sequencer

This block sits behind the bus-write port of a parallel flash device and turns short sequences of bus writes into single combined program operations. A write whose data is a setup code opens a sequence. The writes that follow carry one word each, given as an address and its data. When the last word arrives, a one-cycle start pulse goes to the program controller. The pulse carries the aligned base address, every collected word packed by its low address bits, and a mask that shows which slots hold data.

Four sequence types are recognised. A pair program takes two words in word mode. A quad program takes four words in word mode. A byte-pair program takes two bytes in byte mode. A buffered program first takes a count write giving n, then n+1 words, and launches only when a confirm code follows. At the confirm step, an abort code drops the buffered program without comment. Any word address that falls outside the aligned group, an oversize count, or a wrong code at the confirm step rejects the sequence. A rejection gives a one-cycle error pulse and returns the block to read mode. While the program controller reports busy, setup codes are ignored and only a suspend code is acted on.

Top module: `flash_pgm_seq`

## Requirements
- R1: While reset is held and after it is released, `start_o`, `err_o` and `susp_o` are low and the block is in read mode.
- R2: In word mode, a write of the pair setup code (default 0x0050) followed by two word writes whose addresses differ only in bit 0 raises `start_o` for one cycle, in the cycle after the second word write. The pulse carries kind 0, the address with bit 0 cleared, word k in bits [k*DW +: DW] where k is the word's address bit 0, and valid mask 2'b11.
- R3: In word mode, the quad setup code (default 0x0056) followed by four word writes whose addresses differ only in bits 1:0 starts a program of kind 1. The base address has bits 1:0 cleared, word k sits at slot k = addr[1:0], and the valid mask is 4'b1111.
- R4: In byte mode, the byte-pair setup code (default 0x0051) followed by two writes differing only in address bit 0 starts a program of kind 2. Each slot holds only the low 8 data bits, with the upper bits zero. The pair and quad codes are ignored in byte mode, and the byte-pair code is ignored in word mode.
- R5: A word write whose address differs from the first word's address above the permitted low bits pulses `err_o` for one cycle and produces no start. The block then returns to read mode and accepts a new sequence.
- R6: The buffered setup code (default 0x0025), then a count write with data n, then n+1 word writes in one aligned group of 2^BUF_LG words, then the confirm code (default 0x0029) produce a start of kind 3. The pulse appears in the cycle after the confirm write. Its base has the low BUF_LG bits cleared, and its valid mask has bit k set for each loaded address whose low bits equal k.
- R7: A count write with n greater than 2^BUF_LG-1 pulses `err_o` and returns to read mode.
- R8: At the confirm step, a code other than confirm or abort pulses `err_o` and gives no start.
- R9: At the confirm step, the abort code (default 0x00F0) returns to read mode with neither start nor error.
- R10: While `busy_i` is high, a write of the suspend code (default 0x00B0) in read mode pulses `susp_o` for one cycle. All other writes, setup codes included, are ignored.
- R11: `start_o` and `err_o` each last one cycle and are never high together.
- R12: In read mode, a write whose data is not a recognised code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data or command code |
| byte_mode_i | input | 1 | High selects byte-wide organisation |
| busy_i | input | 1 | Program controller is running |
| start_o | output | 1 | One-cycle launch pulse |
| start_kind_o | output | 2 | 0 pair, 1 quad, 2 byte pair, 3 buffered |
| start_addr_o | output | AW | Aligned base address of the launch |
| start_words_o | output | 2^BUF_LG*DW | Collected words packed by low address bits |
| start_valid_o | output | 2^BUF_LG | Slots that hold a loaded word |
| err_o | output | 1 | One-cycle sequence rejection pulse |
| susp_o | output | 1 | One-cycle suspend request |

## Verification
The assertions assume that each bus write lasts exactly one strobe cycle. They also assume that `busy_i` only moves between sequences, because a busy flag raised in the middle of a sequence does not affect the collection already under way. Byte mode is likewise taken as steady from setup to launch. The stimulus keeps to these limits: it changes `byte_mode_i` and `busy_i` only while the block is in read mode, and it never sends a word whose data happens to equal a command code in read mode, except where that is the point of the test.

// File: rtl/fseq_pkg.sv
// Shared types for the flash program command sequencer.
// Assumes nothing beyond a 2-bit kind code visible at the block's edge.
package fseq_pkg;
    typedef enum logic [1:0] {
        K_PAIR  = 2'd0,
        K_QUAD  = 2'd1,
        K_BPAIR = 2'd2,
        K_BUF   = 2'd3
    } pgm_kind_e;

    typedef enum logic [1:0] {
        S_READ    = 2'd0,
        S_GATHER  = 2'd1,
        S_COUNT   = 2'd2,
        S_CONFIRM = 2'd3
    } seq_state_e;
endpackage

// File: rtl/fseq_cmd_decode.sv
// Classifies one bus-write data value as a command code.
// Assumes the codes are distinct; only meaningful in read mode or at the confirm step.
module fseq_cmd_decode
    import fseq_pkg::*;
#(
    parameter int DW = 16,
    parameter logic [DW-1:0] CMD_PAIR  = DW'('h50),
    parameter logic [DW-1:0] CMD_QUAD  = DW'('h56),
    parameter logic [DW-1:0] CMD_BPAIR = DW'('h51),
    parameter logic [DW-1:0] CMD_BUF   = DW'('h25),
    parameter logic [DW-1:0] CMD_CONF  = DW'('h29),
    parameter logic [DW-1:0] CMD_ABORT = DW'('hF0),
    parameter logic [DW-1:0] CMD_SUSP  = DW'('hB0)
) (
    input  logic [DW-1:0] data_i,
    input  logic          byte_mode_i,
    input  logic          busy_i,
    output logic          setup_o,
    output pgm_kind_e     kind_o,
    output logic [1:0]    span_lg_o,
    output logic          susp_o,
    output logic          conf_o,
    output logic          abort_o
);
    // Setup recognition, gated by organisation mode and controller busy.
    always_comb begin
        setup_o   = 1'b0;
        kind_o    = K_PAIR;
        span_lg_o = 2'd1;
        susp_o    = 1'b0;
        if (busy_i) begin
            susp_o = (data_i == CMD_SUSP);
        end else if (data_i == CMD_PAIR && !byte_mode_i) begin
            setup_o = 1'b1;
        end else if (data_i == CMD_QUAD && !byte_mode_i) begin
            setup_o   = 1'b1;
            kind_o    = K_QUAD;
            span_lg_o = 2'd2;
        end else if (data_i == CMD_BPAIR && byte_mode_i) begin
            setup_o = 1'b1;
            kind_o  = K_BPAIR;
        end else if (data_i == CMD_BUF) begin
            setup_o = 1'b1;
            kind_o  = K_BUF;
        end
    end

    assign conf_o  = (data_i == CMD_CONF);
    assign abort_o = (data_i == CMD_ABORT);
endmodule

// File: rtl/fseq_addr_check.sv
// Compares a word address with the group base above a variable number of low bits.
// Assumes base_i already has its low bits cleared.
module fseq_addr_check #(
    parameter int AW  = 16,
    parameter int LGW = 2
) (
    input  logic [AW-1:0]  addr_i,
    input  logic [AW-1:0]  base_i,
    input  logic [LGW-1:0] lg_i,
    output logic [AW-1:0]  low_mask_o,
    output logic           match_o
);
    // Build a mask with the lg_i lowest bits set.
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            low_mask_o[i] = (i < int'(lg_i));
        end
    end

    assign match_o = ((addr_i ^ base_i) & ~low_mask_o) == '0;
endmodule

// File: rtl/fseq_word_store.sv
// Holds the words of one sequence, one slot per low-address value.
// Assumes DW >= 8; narrow_i keeps only the low byte of captured data.
module fseq_word_store #(
    parameter int DW = 16,
    parameter int LG = 3,
    localparam int MAXW = 1 << LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cap_i,
    input  logic [LG-1:0]     idx_i,
    input  logic [DW-1:0]     data_i,
    input  logic              narrow_i,
    output logic [MAXW*DW-1:0] words_o,
    output logic [MAXW-1:0]   valid_o
);
    localparam logic [DW-1:0] BYTE_MASK = DW'('hFF);

    logic [DW-1:0] cap_data;
    assign cap_data = narrow_i ? (data_i & BYTE_MASK) : data_i;

    for (genvar g = 0; g < MAXW; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        logic          vld_q;
        // Clear on setup, load when the write addresses this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                slot_q <= '0;
                vld_q  <= 1'b0;
            end else if (cap_i && idx_i == LG'(g)) begin
                slot_q <= cap_data;
                vld_q  <= 1'b1;
            end
        end
        assign words_o[g*DW +: DW] = slot_q;
        assign valid_o[g]          = vld_q;
    end
endmodule

// File: rtl/flash_pgm_seq.sv
// Command sequencer for multi-word flash programming.
// Collects pair, quad, byte-pair and buffered program sequences and launches
// one combined program with a one-cycle start pulse.
// Assumes BUF_LG >= 2, one-cycle write strobes, and that busy_i changes
// only between sequences.
module flash_pgm_seq
    import fseq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int BUF_LG = 3,
    parameter logic [DW-1:0] CMD_PAIR  = DW'('h50),
    parameter logic [DW-1:0] CMD_QUAD  = DW'('h56),
    parameter logic [DW-1:0] CMD_BPAIR = DW'('h51),
    parameter logic [DW-1:0] CMD_BUF   = DW'('h25),
    parameter logic [DW-1:0] CMD_CONF  = DW'('h29),
    parameter logic [DW-1:0] CMD_ABORT = DW'('hF0),
    parameter logic [DW-1:0] CMD_SUSP  = DW'('hB0),
    localparam int MAXW = 1 << BUF_LG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic               byte_mode_i,
    input  logic               busy_i,
    output logic               start_o,
    output logic [1:0]         start_kind_o,
    output logic [AW-1:0]      start_addr_o,
    output logic [MAXW*DW-1:0] start_words_o,
    output logic [MAXW-1:0]    start_valid_o,
    output logic               err_o,
    output logic               susp_o
);
    localparam int LGW = $clog2(BUF_LG + 1);
    localparam int CW  = BUF_LG + 1;

    seq_state_e     state_q, state_d;
    pgm_kind_e      kind_q, kind_d;
    logic [LGW-1:0] lg_q, lg_d;
    logic [CW-1:0]  left_q, left_d;
    logic           first_q, first_d;
    logic [AW-1:0]  base_q, base_d;
    logic           start_q, start_d, err_q, err_d, susp_q, susp_d;
    logic           clr, cap;

    logic           dec_setup, dec_susp, dec_conf, dec_abort;
    pgm_kind_e      dec_kind;
    logic [1:0]     dec_lg;
    logic [AW-1:0]  low_mask;
    logic           addr_ok;
    logic [BUF_LG-1:0] idx;

    fseq_cmd_decode #(
        .DW(DW), .CMD_PAIR(CMD_PAIR), .CMD_QUAD(CMD_QUAD), .CMD_BPAIR(CMD_BPAIR),
        .CMD_BUF(CMD_BUF), .CMD_CONF(CMD_CONF), .CMD_ABORT(CMD_ABORT), .CMD_SUSP(CMD_SUSP)
    ) u_dec (
        .data_i      (wr_data_i),
        .byte_mode_i (byte_mode_i),
        .busy_i      (busy_i),
        .setup_o     (dec_setup),
        .kind_o      (dec_kind),
        .span_lg_o   (dec_lg),
        .susp_o      (dec_susp),
        .conf_o      (dec_conf),
        .abort_o     (dec_abort)
    );

    fseq_addr_check #(.AW(AW), .LGW(LGW)) u_chk_addr (
        .addr_i     (wr_addr_i),
        .base_i     (base_q),
        .lg_i       (lg_q),
        .low_mask_o (low_mask),
        .match_o    (addr_ok)
    );

    assign idx = wr_addr_i[BUF_LG-1:0] & low_mask[BUF_LG-1:0];

    fseq_word_store #(.DW(DW), .LG(BUF_LG)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clr),
        .cap_i    (cap),
        .idx_i    (idx),
        .data_i   (wr_data_i),
        .narrow_i (kind_q == K_BPAIR),
        .words_o  (start_words_o),
        .valid_o  (start_valid_o)
    );

    // Sequence state machine: next state, pulses and store control.
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        lg_d    = lg_q;
        left_d  = left_q;
        first_d = first_q;
        base_d  = base_q;
        start_d = 1'b0;
        err_d   = 1'b0;
        susp_d  = 1'b0;
        clr     = 1'b0;
        cap     = 1'b0;
        if (wr_en_i) begin
            case (state_q)
                S_READ: begin
                    susp_d = dec_susp;
                    if (dec_setup) begin
                        clr     = 1'b1;
                        kind_d  = dec_kind;
                        first_d = 1'b1;
                        if (dec_kind == K_BUF) begin
                            state_d = S_COUNT;
                        end else begin
                            state_d = S_GATHER;
                            lg_d    = LGW'(dec_lg);
                            left_d  = CW'(1) << dec_lg;
                        end
                    end
                end
                S_COUNT: begin
                    if (wr_data_i > DW'(MAXW - 1)) begin
                        err_d   = 1'b1;
                        state_d = S_READ;
                    end else begin
                        state_d = S_GATHER;
                        lg_d    = LGW'(BUF_LG);
                        left_d  = CW'(wr_data_i[BUF_LG-1:0]) + CW'(1);
                    end
                end
                S_GATHER: begin
                    if (!first_q && !addr_ok) begin
                        err_d   = 1'b1;
                        state_d = S_READ;
                    end else begin
                        cap     = 1'b1;
                        first_d = 1'b0;
                        if (first_q) base_d = wr_addr_i & ~low_mask;
                        left_d = left_q - CW'(1);
                        if (left_q == CW'(1)) begin
                            if (kind_q == K_BUF) begin
                                state_d = S_CONFIRM;
                            end else begin
                                start_d = 1'b1;
                                state_d = S_READ;
                            end
                        end
                    end
                end
                S_CONFIRM: begin
                    state_d = S_READ;
                    if (dec_conf) start_d = 1'b1;
                    else if (!dec_abort) err_d = 1'b1;
                end
                default: state_d = S_READ;
            endcase
        end
    end

    // State and pulse registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_READ;
            kind_q  <= K_PAIR;
            lg_q    <= '0;
            left_q  <= '0;
            first_q <= 1'b0;
            base_q  <= '0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
            susp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            lg_q    <= lg_d;
            left_q  <= left_d;
            first_q <= first_d;
            base_q  <= base_d;
            start_q <= start_d;
            err_q   <= err_d;
            susp_q  <= susp_d;
        end
    end

    assign start_o      = start_q;
    assign start_kind_o = kind_q;
    assign start_addr_o = base_q;
    assign err_o        = err_q;
    assign susp_o       = susp_q;
endmodule

// File: rtl/flash_pgm_seq_chk.sv
// Property checker for flash_pgm_seq, bound to every instance.
// Assumes one-cycle write strobes on the bus side.
module flash_pgm_seq_chk #(
    parameter int DW   = 16,
    parameter int MAXW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en_i,
    input logic               busy_i,
    input logic               start_o,
    input logic [1:0]         start_kind_o,
    input logic [MAXW*DW-1:0] start_words_o,
    input logic [MAXW-1:0]    start_valid_o,
    input logic               err_o,
    input logic               susp_o
);
    a_r11_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && err_o));
    a_r2_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(wr_en_i));
    a_r5_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_en_i));
    a_r10_susp_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> $past(wr_en_i && busy_i));
    a_r6_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> start_valid_o != '0);
    a_r2_pair_span: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && start_kind_o != 2'd1 && start_kind_o != 2'd3)
            |-> (start_valid_o & ~MAXW'(3)) == '0);
    a_r3_quad_span: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && start_kind_o == 2'd1) |-> (start_valid_o & ~MAXW'(15)) == '0);

    if (DW > 8) begin : g_byte
        for (genvar g = 0; g < MAXW; g++) begin : g_w
            a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (start_o && start_kind_o == 2'd2) |-> start_words_o[g*DW+8 +: DW-8] == '0);
        end
    end
endmodule

bind flash_pgm_seq flash_pgm_seq_chk #(.DW(DW), .MAXW(MAXW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .busy_i        (busy_i),
    .start_o       (start_o),
    .start_kind_o  (start_kind_o),
    .start_words_o (start_words_o),
    .start_valid_o (start_valid_o),
    .err_o         (err_o),
    .susp_o        (susp_o)
);

// File: tb/flash_pgm_seq_tb_top.sv
// Scoreboard bench: drivers queue expected pulses, a monitor compares them.
module flash_pgm_seq_tb_top;
    localparam int AW = 16, DW = 16, LG = 3, MAXW = 1 << LG, WW = MAXW * DW;
    localparam logic [DW-1:0] C_PAIR = 16'h0050, C_QUAD = 16'h0056, C_BPAIR = 16'h0051,
        C_BUF = 16'h0025, C_CONF = 16'h0029, C_ABORT = 16'h00F0, C_SUSP = 16'h00B0;
    localparam int EV_START = 0, EV_ERR = 1, EV_SUSP = 2;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, byte_mode = 1'b0, busy = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic start, err, susp;
    logic [1:0] kind;
    logic [AW-1:0] saddr;
    logic [WW-1:0] swords;
    logic [MAXW-1:0] svalid;

    always #4 clk = ~clk;

    flash_pgm_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .byte_mode_i(byte_mode), .busy_i(busy), .start_o(start), .start_kind_o(kind),
        .start_addr_o(saddr), .start_words_o(swords), .start_valid_o(svalid),
        .err_o(err), .susp_o(susp)
    );

    typedef struct {
        int ev; int kd; logic [AW-1:0] addr; logic [WW-1:0] words;
        logic [MAXW-1:0] valid; string tag;
    } exp_t;
    exp_t exp_q[$];
    int checks = 0, errors = 0, pushed = 0, seen = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic push(input int ev, input int kd, input logic [AW-1:0] a,
                        input logic [WW-1:0] w, input logic [MAXW-1:0] v, input string tag);
        exp_t e;
        e.ev = ev; e.kd = kd; e.addr = a; e.words = w; e.valid = v; e.tag = tag;
        exp_q.push_back(e);
        pushed++;
    endtask

    // One bus write, called and returning at a falling edge.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic quiet(input string tag);
        repeat (3) @(negedge clk);
        chk(seen == pushed, tag, WW'(seen), WW'(pushed));
    endtask

    // Monitor: every pulse must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && (start || err || susp)) begin
            exp_t e;
            int ev;
            seen++;
            ev = start ? EV_START : (err ? EV_ERR : EV_SUSP);
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected pulse", WW'(ev), '1);
            end else begin
                e = exp_q.pop_front();
                chk(ev == e.ev, {e.tag, " event"}, WW'(ev), WW'(e.ev));
                if (ev == EV_START && e.ev == EV_START) begin
                    chk(kind == 2'(e.kd), {e.tag, " kind"}, WW'(kind), WW'(e.kd));
                    chk(saddr == e.addr, {e.tag, " addr"}, WW'(saddr), WW'(e.addr));
                    chk(swords == e.words, {e.tag, " words"}, swords, e.words);
                    chk(svalid == e.valid, {e.tag, " valid"}, WW'(svalid), WW'(e.valid));
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] w;
        repeat (3) @(negedge clk);
        chk(!start && !err && !susp, "R1 in reset", WW'({start, err, susp}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!start && !err && !susp, "R1 after reset", WW'({start, err, susp}), '0);

        // R2 pair program, words out of order
        w = '0; w[0*DW +: DW] = 16'hBBBB; w[1*DW +: DW] = 16'hAAAA;
        bus_wr(16'h0000, C_PAIR); bus_wr(16'h1235, 16'hAAAA);
        push(EV_START, 0, 16'h1234, w, 8'h03, "R2 pair");
        bus_wr(16'h1234, 16'hBBBB);

        // R12 unknown code ignored, then R3 quad program
        bus_wr(16'h0000, 16'h00AA);
        quiet("R12 unknown code");
        w = '0;
        for (int i = 0; i < 4; i++) w[i*DW +: DW] = 16'hD000 + DW'(i);
        bus_wr(16'h0000, C_QUAD);
        bus_wr(16'h2003, 16'hD003); bus_wr(16'h2000, 16'hD000); bus_wr(16'h2002, 16'hD002);
        push(EV_START, 1, 16'h2000, w, 8'h0F, "R3 quad");
        bus_wr(16'h2001, 16'hD001);

        // R4 mode gating and byte-pair program
        byte_mode = 1'b1;
        bus_wr(16'h0000, C_PAIR); bus_wr(16'h0010, 16'h2222);
        quiet("R4 pair code in byte mode");
        w = '0; w[0*DW +: DW] = 16'h0012; w[1*DW +: DW] = 16'h0034;
        bus_wr(16'h0000, C_BPAIR); bus_wr(16'h0041, 16'hCD34);
        push(EV_START, 2, 16'h0040, w, 8'h03, "R4 byte pair");
        bus_wr(16'h0040, 16'hAB12);
        byte_mode = 1'b0;
        bus_wr(16'h0000, C_BPAIR); bus_wr(16'h0010, 16'h3333);
        quiet("R4 byte code in word mode");

        // R5 misaligned pair, then misaligned quad
        bus_wr(16'h0000, C_PAIR); bus_wr(16'h1000, 16'h0001);
        push(EV_ERR, 0, '0, '0, '0, "R5 pair misaligned");
        bus_wr(16'h1002, 16'h0002);
        bus_wr(16'h0000, C_QUAD);
        bus_wr(16'h3000, 16'h0001); bus_wr(16'h3001, 16'h0002); bus_wr(16'h3002, 16'h0003);
        push(EV_ERR, 0, '0, '0, '0, "R5 quad misaligned");
        bus_wr(16'h3004, 16'h0004);
        quiet("R5 no start after reject");

        // R6 buffered program with three words
        w = '0; w[5*DW +: DW] = 16'h0505; w[3*DW +: DW] = 16'h0303; w[7*DW +: DW] = 16'h0707;
        bus_wr(16'h4000, C_BUF); bus_wr(16'h4000, 16'h0002);
        bus_wr(16'h4005, 16'h0505); bus_wr(16'h4003, 16'h0303); bus_wr(16'h4007, 16'h0707);
        quiet("R6 waits for confirm");
        push(EV_START, 3, 16'h4000, w, 8'hA8, "R6 buffered");
        bus_wr(16'h4000, C_CONF);

        // R6 full buffer
        w = '0;
        for (int i = 0; i < MAXW; i++) w[i*DW +: DW] = 16'h5A00 + DW'(i);
        bus_wr(16'h5000, C_BUF); bus_wr(16'h5000, 16'h0007);
        for (int i = 0; i < MAXW; i++) bus_wr(16'h5000 + AW'(i), 16'h5A00 + DW'(i));
        push(EV_START, 3, 16'h5000, w, 8'hFF, "R6 full buffer");
        bus_wr(16'h5000, C_CONF);

        // R7 oversize count
        bus_wr(16'h6000, C_BUF);
        push(EV_ERR, 0, '0, '0, '0, "R7 count too large");
        bus_wr(16'h6000, 16'h0008);

        // R8 wrong code at confirm step
        bus_wr(16'h6000, C_BUF); bus_wr(16'h6000, 16'h0000); bus_wr(16'h6001, 16'h1111);
        push(EV_ERR, 0, '0, '0, '0, "R8 bad confirm");
        bus_wr(16'h6000, 16'h1234);

        // R9 abort at confirm step
        bus_wr(16'h7000, C_BUF); bus_wr(16'h7000, 16'h0001);
        bus_wr(16'h7000, 16'h0101); bus_wr(16'h7001, 16'h0202);
        bus_wr(16'h7000, C_ABORT);
        quiet("R9 abort silent");

        // R10 busy: setup ignored, suspend honoured
        busy = 1'b1;
        bus_wr(16'h0000, C_PAIR); bus_wr(16'h0008, 16'h4444);
        quiet("R10 setup ignored while busy");
        push(EV_SUSP, 0, '0, '0, '0, "R10 suspend");
        bus_wr(16'h0000, C_SUSP);
        busy = 1'b0;
        bus_wr(16'h0000, 16'h1111);
        quiet("R10 back in read");

        // R11 back-to-back pair after the above, read mode intact
        w = '0; w[0*DW +: DW] = 16'hCAFE; w[1*DW +: DW] = 16'hBEEF;
        bus_wr(16'h0000, C_PAIR); bus_wr(16'h0A00, 16'hCAFE);
        push(EV_START, 0, 16'h0A00, w, 8'h03, "R11 pair after busy");
        bus_wr(16'h0A01, 16'hBEEF);
        @(negedge clk);
        chk(!start && !err, "R11 pulse width", WW'({start, err}), '0);

        quiet("final pulse count");
        chk(exp_q.size() == 0, "final queue empty", WW'(exp_q.size()), '0);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule